// File: doc/BRIEF.md
# Batch-Aware DRAM Request Arbiter

This block picks one request per DRAM cycle out of a buffer of pending memory requests. Each buffer entry presents a valid flag, a thread number, a target bank, a target row, an age count and a batch mark. Alongside the buffer the arbiter sees a rank value for every thread, the row currently open in every bank, and a per-bank ready flag. It returns a registered grant: a valid bit and the index of the chosen entry.

In batch policy the winner is decided by a strict layered order. Marked requests come first, then requests that hit the open row of their bank, then requests from the thread with the larger rank value, and finally the oldest request. An unmarked request may only compete when its bank holds no marked work, so banks without batch work keep busy instead of idling. A mode input switches to the baseline policy, which disregards marks and ranks and orders by row hit and then by age. Batch forming and rank computation happen elsewhere.

Top module: `batch_req_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `grant_valid` is 0 and `grant_idx` is 0.
- R2: An entry competes only if its valid bit is 1 and `bank_ready` is 1 for its bank; when no entry competes, `grant_valid` is 0.
- R3: In batch policy (`baseline_mode`=0), a competing entry with mark bit 1 is granted ahead of every entry with mark bit 0, regardless of row hit, rank or age.
- R4: Among competing entries equal in mark, an entry whose row equals the open row of its bank is granted ahead of one whose row differs.
- R5: In batch policy, among entries equal in mark and row hit, the entry whose thread has the larger `thread_rank` value is granted.
- R6: Among entries equal in all higher levels, the larger age value (older) wins; on equal age the lower entry index wins.
- R7: In batch policy, an unmarked entry cannot win while any valid marked entry targets the same bank; an unmarked entry to a ready bank is granted when every marked entry targets a bank that is not ready.
- R8: With `baseline_mode`=1, marks and thread ranks have no effect: row hit first, then age, then lower index.
- R9: The grant is registered: the result for inputs present at a rising edge appears just after that edge, stays unchanged until the next edge, and a new decision is taken at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| baseline_mode | input | 1 | 1 = row hit then age only; 0 = batch policy |
| req_valid | input | N_ENT | Entry holds a pending request |
| req_mark | input | N_ENT | Entry belongs to the current batch |
| req_thread | input | N_ENT*THR_W | Thread number per entry, entry i at bits [i*THR_W +: THR_W] |
| req_bank | input | N_ENT*BANK_W | Target bank per entry |
| req_row | input | N_ENT*ROW_W | Target row per entry |
| req_age | input | N_ENT*AGE_W | Age per entry, larger is older |
| thread_rank | input | N_THR*RANK_W | Rank per thread, larger is preferred |
| open_row | input | N_BANK*ROW_W | Row currently open in each bank |
| bank_ready | input | N_BANK | Bank can accept a command this cycle |
| grant_valid | output | 1 | A request was chosen |
| grant_idx | output | IDX_W | Index of the chosen entry |

## Verification
The selection tree is combinational and only the grant register sits between the request inputs and the outputs, so each decision is due exactly one rising edge after the inputs are set. The bench changes inputs on the falling edge and samples one time unit after the next rising edge; for the registered behaviour it also samples before that edge to see that the previous grant is still held. Every expected index is worked out by hand from the priority order for that scenario.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

    localparam int DEF_ENTRIES = 8;
    localparam int DEF_THREADS = 4;
    localparam int DEF_BANKS   = 4;
    localparam int DEF_ROW_W   = 8;
    localparam int DEF_AGE_W   = 6;
    localparam int DEF_RANK_W  = 2;

    typedef enum logic {
        POL_BATCH    = 1'b0,
        POL_BASELINE = 1'b1
    } policy_e;

    // priority key layout, most significant first:
    // eligible | mark | row hit | rank | age
    function automatic int key_width(input int rank_w, input int age_w);
        return 3 + rank_w + age_w;
    endfunction

endpackage

// File: rtl/bank_mark_scan.sv
module bank_mark_scan #(
    parameter int N_ENT  = 8,
    parameter int N_BANK = 4,
    localparam int BANK_W = $clog2(N_BANK)
) (
    input  logic [N_ENT-1:0]        req_valid,
    input  logic [N_ENT-1:0]        req_mark,
    input  logic [N_ENT*BANK_W-1:0] req_bank,
    output logic [N_BANK-1:0]       bank_has_mark
);
    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        always_comb begin
            bank_has_mark[b] = 1'b0;
            for (int i = 0; i < N_ENT; i++) begin
                if (req_valid[i] && req_mark[i] &&
                    (req_bank[i*BANK_W +: BANK_W] == BANK_W'(b)))
                    bank_has_mark[b] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/req_key_build.sv
module req_key_build
    import bsched_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int N_THR  = 4,
    parameter int N_BANK = 4,
    parameter int ROW_W  = 8,
    parameter int AGE_W  = 6,
    parameter int RANK_W = 2,
    localparam int THR_W  = $clog2(N_THR),
    localparam int BANK_W = $clog2(N_BANK),
    localparam int KEY_W  = key_width(RANK_W, AGE_W)
) (
    input  logic                     baseline_mode,
    input  logic [N_ENT-1:0]         req_valid,
    input  logic [N_ENT-1:0]         req_mark,
    input  logic [N_ENT*THR_W-1:0]   req_thread,
    input  logic [N_ENT*BANK_W-1:0]  req_bank,
    input  logic [N_ENT*ROW_W-1:0]   req_row,
    input  logic [N_ENT*AGE_W-1:0]   req_age,
    input  logic [N_THR*RANK_W-1:0]  thread_rank,
    input  logic [N_BANK*ROW_W-1:0]  open_row,
    input  logic [N_BANK-1:0]        bank_ready,
    input  logic [N_BANK-1:0]        bank_has_mark,
    output logic [N_ENT-1:0]         elig,
    output logic [N_ENT*KEY_W-1:0]   keys
);
    policy_e pol;
    assign pol = policy_e'(baseline_mode);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic [BANK_W-1:0] bnk;
        logic [THR_W-1:0]  thr;
        logic              hit;
        logic              mk;
        logic [RANK_W-1:0] rnk;

        assign bnk = req_bank[i*BANK_W +: BANK_W];
        assign thr = req_thread[i*THR_W +: THR_W];
        assign hit = (req_row[i*ROW_W +: ROW_W] == open_row[bnk*ROW_W +: ROW_W]);
        assign mk  = (pol == POL_BATCH) && req_mark[i];
        assign rnk = (pol == POL_BATCH) ? thread_rank[thr*RANK_W +: RANK_W] : '0;

        // unmarked work only where the bank has nothing marked (batch policy)
        assign elig[i] = req_valid[i] && bank_ready[bnk] &&
                         ((pol == POL_BASELINE) || req_mark[i] || !bank_has_mark[bnk]);

        assign keys[i*KEY_W +: KEY_W] = elig[i]
            ? {1'b1, mk, hit, rnk, req_age[i*AGE_W +: AGE_W]}
            : '0;
    end
endmodule

// File: rtl/prio_tree.sv
module prio_tree #(
    parameter int N_ENT = 8,
    parameter int KEY_W = 11,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int P     = 1 << IDX_W
) (
    input  logic [N_ENT*KEY_W-1:0] keys,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx
);
    logic [KEY_W-1:0] key_n [2*P-1];
    logic [IDX_W-1:0] idx_n [2*P-1];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N_ENT) begin : g_real
            assign key_n[P-1+i] = keys[i*KEY_W +: KEY_W];
        end else begin : g_pad
            assign key_n[P-1+i] = '0;
        end
        assign idx_n[P-1+i] = IDX_W'(i);
    end

    // left subtree always holds lower indices, so ties go left
    for (genvar k = 0; k < P-1; k++) begin : g_node
        logic take_l;
        assign take_l   = key_n[2*k+1] >= key_n[2*k+2];
        assign key_n[k] = take_l ? key_n[2*k+1] : key_n[2*k+2];
        assign idx_n[k] = take_l ? idx_n[2*k+1] : idx_n[2*k+2];
    end

    assign win_valid = key_n[0][KEY_W-1];
    assign win_idx   = idx_n[0];
endmodule

// File: rtl/batch_req_arbiter.sv
module batch_req_arbiter
    import bsched_pkg::*;
#(
    parameter int N_ENT  = DEF_ENTRIES,
    parameter int N_THR  = DEF_THREADS,
    parameter int N_BANK = DEF_BANKS,
    parameter int ROW_W  = DEF_ROW_W,
    parameter int AGE_W  = DEF_AGE_W,
    parameter int RANK_W = DEF_RANK_W,
    localparam int THR_W  = $clog2(N_THR),
    localparam int BANK_W = $clog2(N_BANK),
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int KEY_W  = key_width(RANK_W, AGE_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    baseline_mode,
    input  logic [N_ENT-1:0]        req_valid,
    input  logic [N_ENT-1:0]        req_mark,
    input  logic [N_ENT*THR_W-1:0]  req_thread,
    input  logic [N_ENT*BANK_W-1:0] req_bank,
    input  logic [N_ENT*ROW_W-1:0]  req_row,
    input  logic [N_ENT*AGE_W-1:0]  req_age,
    input  logic [N_THR*RANK_W-1:0] thread_rank,
    input  logic [N_BANK*ROW_W-1:0] open_row,
    input  logic [N_BANK-1:0]       bank_ready,
    output logic                    grant_valid,
    output logic [IDX_W-1:0]        grant_idx
);
    logic [N_BANK-1:0]      bank_has_mark;
    logic [N_ENT-1:0]       elig;
    logic [N_ENT*KEY_W-1:0] keys;
    logic                   win_valid;
    logic [IDX_W-1:0]       win_idx;
    logic [BANK_W-1:0]      win_bank;

    bank_mark_scan #(.N_ENT(N_ENT), .N_BANK(N_BANK)) u_scan (
        .req_valid     (req_valid),
        .req_mark      (req_mark),
        .req_bank      (req_bank),
        .bank_has_mark (bank_has_mark)
    );

    req_key_build #(
        .N_ENT(N_ENT), .N_THR(N_THR), .N_BANK(N_BANK),
        .ROW_W(ROW_W), .AGE_W(AGE_W), .RANK_W(RANK_W)
    ) u_keys (
        .baseline_mode (baseline_mode),
        .req_valid     (req_valid),
        .req_mark      (req_mark),
        .req_thread    (req_thread),
        .req_bank      (req_bank),
        .req_row       (req_row),
        .req_age       (req_age),
        .thread_rank   (thread_rank),
        .open_row      (open_row),
        .bank_ready    (bank_ready),
        .bank_has_mark (bank_has_mark),
        .elig          (elig),
        .keys          (keys)
    );

    prio_tree #(.N_ENT(N_ENT), .KEY_W(KEY_W)) u_tree (
        .keys      (keys),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    assign win_bank = req_bank[win_idx*BANK_W +: BANK_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            grant_idx   <= '0;
        end else begin
            grant_valid <= win_valid;
            grant_idx   <= win_valid ? win_idx : '0;
        end
    end

    // R2
    win_ready_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (req_valid[win_idx] && bank_ready[win_bank]));

    // R2
    no_grant_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |=> !grant_valid);

    // R3
    mark_first_chk: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !baseline_mode && ((elig & req_mark) != '0)) |-> req_mark[win_idx]);

    // R7
    bank_block_chk: assert property (@(posedge clk) disable iff (rst)
        (win_valid && !baseline_mode && !req_mark[win_idx]) |-> !bank_has_mark[win_bank]);

endmodule

// File: tb/tb_batch_req_arbiter.sv
`timescale 1ns/1ps
module tb_batch_req_arbiter;
    localparam int N_ENT = 8, N_THR = 4, N_BANK = 4;
    localparam int ROW_W = 8, AGE_W = 6, RANK_W = 2;
    localparam int THR_W = 2, BANK_W = 2, IDX_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baseline_mode = 1'b0;
    logic [N_ENT-1:0]        req_valid, req_mark;
    logic [N_ENT*THR_W-1:0]  req_thread;
    logic [N_ENT*BANK_W-1:0] req_bank;
    logic [N_ENT*ROW_W-1:0]  req_row;
    logic [N_ENT*AGE_W-1:0]  req_age;
    logic [N_THR*RANK_W-1:0] thread_rank;
    logic [N_BANK*ROW_W-1:0] open_row;
    logic [N_BANK-1:0]       bank_ready;
    logic                    grant_valid;
    logic [IDX_W-1:0]        grant_idx;

    logic              v  [N_ENT];
    logic              mk [N_ENT];
    logic [THR_W-1:0]  th [N_ENT];
    logic [BANK_W-1:0] bk [N_ENT];
    logic [ROW_W-1:0]  rw [N_ENT];
    logic [AGE_W-1:0]  ag [N_ENT];
    logic [RANK_W-1:0] rk [N_THR];
    logic [ROW_W-1:0]  orow [N_BANK];
    logic              rdy [N_BANK];

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            req_valid[i] = v[i];
            req_mark[i]  = mk[i];
            req_thread[i*THR_W +: THR_W] = th[i];
            req_bank[i*BANK_W +: BANK_W] = bk[i];
            req_row[i*ROW_W +: ROW_W]    = rw[i];
            req_age[i*AGE_W +: AGE_W]    = ag[i];
        end
        for (int t = 0; t < N_THR; t++) thread_rank[t*RANK_W +: RANK_W] = rk[t];
        for (int b = 0; b < N_BANK; b++) begin
            open_row[b*ROW_W +: ROW_W] = orow[b];
            bank_ready[b] = rdy[b];
        end
    end

    batch_req_arbiter dut (
        .clk(clk), .rst(rst), .baseline_mode(baseline_mode),
        .req_valid(req_valid), .req_mark(req_mark), .req_thread(req_thread),
        .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
        .thread_rank(thread_rank), .open_row(open_row), .bank_ready(bank_ready),
        .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

    task automatic clear_all();
        for (int i = 0; i < N_ENT; i++) begin
            v[i] = 0; mk[i] = 0; th[i] = '0; bk[i] = '0; rw[i] = '0; ag[i] = '0;
        end
        for (int t = 0; t < N_THR; t++) rk[t] = '0;
        for (int b = 0; b < N_BANK; b++) begin orow[b] = '0; rdy[b] = 1; end
        baseline_mode = 0;
    endtask

    task automatic put(int i, int thr, int bank, int row, int age, bit mark);
        v[i] = 1; th[i] = THR_W'(thr); bk[i] = BANK_W'(bank);
        rw[i] = ROW_W'(row); ag[i] = AGE_W'(age); mk[i] = mark;
    endtask

    task automatic chk(bit ev, int ei, string tag);
        n_checks++;
        if (grant_valid !== ev || (ev && grant_idx !== IDX_W'(ei))) begin
            n_fail++;
            $display("FAIL %s: got valid=%0d idx=%0d, expected valid=%0d idx=%0d",
                     tag, grant_valid, grant_idx, ev, ei);
        end
    endtask

    task automatic new_case();
        @(negedge clk);
        clear_all();
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        clear_all();
        put(3, 0, 0, 0, 5, 1);
        rst = 1;
        repeat (3) @(posedge clk);
        #1 chk(0, 0, "R1 during reset");
        @(negedge clk);
        rst = 0;
        clear_all();
        settle();
        chk(0, 0, "R1 after reset");
    endtask

    task automatic t_eligible();
        new_case();
        settle();
        chk(0, 0, "R2 empty buffer");
        new_case();
        rdy[2] = 0;
        put(4, 0, 2, 0, 30, 1);
        settle();
        chk(0, 0, "R2 bank not ready");
        new_case();
        rdy[2] = 0;
        put(4, 0, 2, 0, 30, 1);
        put(6, 0, 3, 0, 1, 0);
        settle();
        chk(1, 6, "R2 only ready bank competes");
    endtask

    task automatic t_mark();
        new_case();
        rk[1] = 3;
        put(2, 1, 0, 0, 60, 0);   // unmarked, hit, top rank, old
        put(5, 0, 1, 9, 1, 1);    // marked, miss, young
        settle();
        chk(1, 5, "R3 marked beats unmarked");
    endtask

    task automatic t_hit();
        new_case();
        orow[2] = 8'd7;
        put(1, 0, 2, 3, 50, 1);   // miss
        put(6, 0, 2, 7, 2, 1);    // hit
        settle();
        chk(1, 6, "R4 row hit beats miss");
    endtask

    task automatic t_rank();
        new_case();
        rk[1] = 3; rk[2] = 1;
        put(0, 2, 0, 0, 40, 1);
        put(3, 1, 1, 0, 4, 1);
        settle();
        chk(1, 3, "R5 higher rank wins");
    endtask

    task automatic t_age();
        new_case();
        put(4, 0, 0, 0, 10, 1);
        put(7, 0, 1, 0, 20, 1);
        settle();
        chk(1, 7, "R6 older wins");
        new_case();
        put(4, 0, 0, 0, 15, 1);
        put(7, 0, 1, 0, 15, 1);
        settle();
        chk(1, 4, "R6 equal age lower index");
    endtask

    task automatic t_work_conserve();
        new_case();
        rk[3] = 3;
        orow[2] = 8'd4;
        put(0, 0, 2, 1, 1, 1);    // marked miss young
        put(3, 3, 2, 4, 40, 0);   // unmarked hit, same bank
        settle();
        chk(1, 0, "R7 unmarked blocked by marked in same bank");
        new_case();
        rdy[1] = 0;
        put(0, 0, 1, 0, 50, 1);   // marked but bank not ready
        put(3, 0, 2, 0, 1, 0);    // unmarked to idle bank
        settle();
        chk(1, 3, "R7 unmarked served while marked bank waits");
    endtask

    task automatic t_baseline();
        new_case();
        baseline_mode = 1;
        rk[2] = 3;
        orow[1] = 8'd5;
        put(2, 2, 0, 9, 60, 1);   // marked, top rank, miss
        put(5, 0, 1, 5, 1, 0);    // unmarked hit
        settle();
        chk(1, 5, "R8 baseline ignores mark and rank");
        new_case();
        baseline_mode = 1;
        orow[0] = 8'd1;
        put(1, 0, 0, 2, 3, 1);    // marked miss young
        put(6, 0, 0, 3, 30, 0);   // unmarked miss old, same bank
        settle();
        chk(1, 6, "R8 baseline oldest among misses");
    endtask

    task automatic t_register();
        new_case();
        put(2, 0, 0, 0, 5, 1);
        settle();
        chk(1, 2, "R9 first decision");
        @(negedge clk);
        clear_all();
        put(6, 0, 3, 0, 5, 1);
        #1 chk(1, 2, "R9 grant held before edge");
        settle();
        chk(1, 6, "R9 new decision after edge");
        settle();
        chk(1, 6, "R9 steady inputs give same grant");
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_eligible();
        t_mark();
        t_hit();
        t_rank();
        t_age();
        t_work_conserve();
        t_baseline();
        t_register();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule